// File: doc/BRIEF.md
# Bus Error Response Controller

This block decides how every processor bus cycle terminates. A cycle ends either with a normal acknowledge or with an error acknowledge. The block takes abstract status from the memory path, the PCI initiator path, the cache data-parity checker and the transfer checker, and from them produces the termination strobes. It also drives a processor interrupt, a stretched data-parity flag and an all-ones data select. The memory controller, the PCI transaction engine and address decoding sit outside the block and are seen only as request and status pins. A mask input turns error acknowledges into normal ones, which helps when debugging. Programmed-I/O cycles are exempt from the mask.

Parity errors on the later beats of a burst cannot stop the burst that is already running. They are deferred: the block raises the interrupt, and the processor then runs an interrupt-acknowledge read. The block answers that read itself with all ones and an error acknowledge, and does not forward it to PCI. For PCI-mastered memory traffic, a memory parity error sets a sticky flag. While the flag is set, every later PCI request to memory is target-aborted. The flag clears when the processor reads the error address.

The controller is a single state machine with these states:
- ST_IDLE: waits for a request.
- ST_MEM_ISSUE: a one-clock memory start.
- ST_MEM_WAIT: waits for a memory beat.
- ST_PCI_ISSUE: a one-clock PCI start.
- ST_SEL_WAIT: waits for device select.
- ST_RSP_WAIT: waits for the target response.
- ST_END: one clock of termination.

Its transitions are:
- ST_IDLE to ST_END: immediate finish for errors, out-of-range, local interrupt acknowledge and error-address reads.
- ST_IDLE to ST_MEM_ISSUE.
- ST_IDLE to ST_PCI_ISSUE.
- ST_MEM_ISSUE to ST_MEM_WAIT.
- ST_MEM_WAIT to ST_END: on each beat.
- ST_PCI_ISSUE to ST_SEL_WAIT.
- ST_SEL_WAIT to ST_RSP_WAIT: on device select.
- ST_SEL_WAIT to ST_END: when the select window expires.
- ST_RSP_WAIT to ST_END: on done, abort or timeout.
- ST_END to ST_MEM_WAIT: more burst beats remain.
- ST_END to ST_IDLE: the cycle is finished.

Top module: `berc_top`

## Requirements
- R1: A legal, in-range memory cycle pulses `mem_go` for one clock. Each `mem_beat` is then answered by `ta` for exactly one clock, one clock after the beat. `ta` and `tea` are never high together.
- R2: A programmed-I/O cycle (`cpu_pio`=1) or an illegal size/alignment (`cpu_bad_size`=1) ends with `tea` one clock after `cpu_req`. A memory beat with `mem_par_err`=1 ends the cycle with `tea`.
- R3: With `mask_err`=1, every case that would give `tea` gives `ta` instead, except programmed-I/O cycles, which still get `tea`.
- R4: `dpe_in` on beat 0 of a memory cycle ends it with `tea` and raises no interrupt. `dpe_in` on beat 1, 2 or 3 of a burst gets `ta` and sets `int_cpu`.
- R5: Each beat with `dpe_in`=1 makes `dpe_flag` high for exactly DPE_HOLD (default 2) clocks. The flag starts in the clock in which that beat is terminated.
- R6: `int_cpu` is set by a late-beat data parity error, by `pm_par_err` and by `nmi_req`. It stays high until a locally answered interrupt-acknowledge read.
- R7: Target code 3 is interrupt acknowledge. If `int_cpu` is high, that read is not forwarded (`pci_go` stays 0) and ends in one clock with `ones_sel`=1 and `tea` (`ta` if masked). `int_cpu` falls on the next clock. If `int_cpu` is low, the read goes to PCI.
- R8: Target codes are 1 for PCI and 2 for configuration. `pci_devsel` is accepted in clocks 1 to DEVSEL_CLKS (default 7) after the `pci_go` clock. Without it, the termination comes one clock later: `tea` for PCI, `ta` for configuration, and `ones_sel` on reads in both cases.
- R9: After select, `pci_done` gives `ta` and `pci_tabort` gives `tea`. If neither arrives within TMO_CLKS (default 1980) clocks, the cycle ends with `tea` one clock later.
- R10: A memory request (target code 0) with `cpu_oor`=1 ends one clock later with `ta` and never asserts `mem_go`. On a read `ones_sel`=1; on a write `ones_sel`=0.
- R11: After `pm_par_err`, every `pm_req` gives `pm_tabort` one clock later. An error-address read (target code 4) ends with `ta` and clears this state; before any parity error `pm_tabort` stays 0.
- R12: A burst memory cycle (`cpu_burst`=1) receives BURST_BEATS (default 4) separate one-clock `ta` pulses and then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_err | input | 1 | Replace error acknowledge by normal acknowledge (not for programmed I/O) |
| cpu_req | input | 1 | One-clock start of a processor cycle |
| cpu_tgt | input | 3 | Target: 0 memory, 1 PCI, 2 configuration, 3 interrupt acknowledge, 4 error address |
| cpu_read | input | 1 | Cycle is a read |
| cpu_burst | input | 1 | Cycle is a burst |
| cpu_pio | input | 1 | Programmed-I/O cycle |
| cpu_bad_size | input | 1 | Illegal size or alignment |
| cpu_oor | input | 1 | Memory address out of range |
| mem_go | output | 1 | Start memory access |
| mem_beat | input | 1 | Memory beat complete |
| mem_par_err | input | 1 | Memory parity error on this beat |
| dpe_in | input | 1 | Cache data parity error on this beat |
| pci_go | output | 1 | Start PCI transaction |
| pci_devsel | input | 1 | Target claimed the PCI cycle |
| pci_done | input | 1 | PCI target completed |
| pci_tabort | input | 1 | PCI target abort |
| pm_req | input | 1 | PCI-mastered memory request |
| pm_par_err | input | 1 | Memory parity error on a PCI-mastered cycle |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ta | output | 1 | Normal acknowledge |
| tea | output | 1 | Error acknowledge |
| int_cpu | output | 1 | Processor interrupt request |
| dpe_flag | output | 1 | Stretched data parity error flag |
| ones_sel | output | 1 | Drive all-ones read data |
| pm_tabort | output | 1 | Target abort for PCI-mastered request |

## Verification
Every result comes from a register, so it is due one clock after the input that causes it:
- `mem_go` and `pci_go` appear one clock after `cpu_req`.
- `ta`/`tea` come one clock after `cpu_req` for immediate endings, and one clock after `mem_beat`, `pci_done`, `pci_tabort` or the window expiry otherwise.
- `int_cpu`, `pm_tabort` and the start of `dpe_flag` also follow their cause by one clock.

The bench drives inputs just after a falling edge and samples just after the next falling edge. Each wait is a counted number of clocks, so every check lands on the clock in which the output is due. The window boundaries are checked on both sides: one clock before the expiry nothing has happened, and one clock later the error is present.

// File: rtl/berc_pkg.sv
package berc_pkg;

    typedef enum logic [2:0] {
        TGT_MEM   = 3'd0,
        TGT_PCI   = 3'd1,
        TGT_CFG   = 3'd2,
        TGT_IACK  = 3'd3,
        TGT_EADDR = 3'd4
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_ISSUE,
        ST_MEM_WAIT,
        ST_PCI_ISSUE,
        ST_SEL_WAIT,
        ST_RSP_WAIT,
        ST_END
    } st_e;

    typedef struct packed {
        logic err;        // finish with error acknowledge
        logic ones;       // drive all-ones data
        logic last;       // cycle complete after this termination
        logic clr_int;    // local interrupt acknowledge
        logic clr_sticky; // error address read
    } term_t;

endpackage

// File: rtl/berc_window.sv
module berc_window #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && !hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = en && (cnt == limit);

endmodule

// File: rtl/berc_stretch.sv
module berc_stretch #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic flag
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (trig) begin
            left <= HW'(HOLD);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign flag = (left != '0);

    AST_DPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |=> flag); // R5

endmodule

// File: rtl/berc_pm_guard.sv
module berc_pm_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic par_err,
    input  logic req,
    input  logic clr,
    output logic tabort
);
    logic sticky;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            tabort <= 1'b0;
        end else begin
            if (par_err) begin
                sticky <= 1'b1;
            end else if (clr) begin
                sticky <= 1'b0;
            end
            tabort <= req && sticky;
        end
    end

    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tabort |-> $past(req)); // R11

endmodule

// File: rtl/berc_top.sv
module berc_top
    import berc_pkg::*;
#(
    parameter int DEVSEL_CLKS = 7,
    parameter int TMO_CLKS    = 1980,
    parameter int BURST_BEATS = 4,
    parameter int DPE_HOLD    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_err,
    input  logic       cpu_req,
    input  logic [2:0] cpu_tgt,
    input  logic       cpu_read,
    input  logic       cpu_burst,
    input  logic       cpu_pio,
    input  logic       cpu_bad_size,
    input  logic       cpu_oor,
    output logic       mem_go,
    input  logic       mem_beat,
    input  logic       mem_par_err,
    input  logic       dpe_in,
    output logic       pci_go,
    input  logic       pci_devsel,
    input  logic       pci_done,
    input  logic       pci_tabort,
    input  logic       pm_req,
    input  logic       pm_par_err,
    input  logic       nmi_req,
    output logic       ta,
    output logic       tea,
    output logic       int_cpu,
    output logic       dpe_flag,
    output logic       ones_sel,
    output logic       pm_tabort
);
    localparam int WMAX = (TMO_CLKS > DEVSEL_CLKS) ? TMO_CLKS : DEVSEL_CLKS;
    localparam int CW   = $clog2(WMAX + 1);
    localparam int BW   = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    st_e           state, st_n;
    term_t         term_q, term_n;
    tgt_e          c_tgt;
    logic          c_read;
    logic          c_burst;
    logic [BW-1:0] beat_q;
    logic          int_pend;
    logic          win_clr, win_en, win_hit;
    logic [CW-1:0] win_lim;
    logic          dpe_hit, late_dpe;

    // Error acknowledge survives the mask only on programmed-I/O cycles.
    function automatic logic err_kept(input logic pio, input logic mask);
        return pio || !mask;
    endfunction

    // ---------------- next state ----------------
    always_comb begin
        st_n   = state;
        term_n = term_q;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    term_n      = '0;
                    term_n.last = 1'b1;
                    if (cpu_pio || cpu_bad_size) begin
                        st_n       = ST_END;
                        term_n.err = err_kept(cpu_pio, mask_err);
                    end else begin
                        unique case (tgt_e'(cpu_tgt))
                            TGT_MEM: begin
                                if (cpu_oor) begin
                                    st_n        = ST_END;
                                    term_n.ones = cpu_read;
                                end else begin
                                    st_n = ST_MEM_ISSUE;
                                end
                            end
                            TGT_PCI, TGT_CFG: st_n = ST_PCI_ISSUE;
                            TGT_IACK: begin
                                if (int_pend) begin
                                    st_n           = ST_END;
                                    term_n.err     = err_kept(1'b0, mask_err);
                                    term_n.ones    = 1'b1;
                                    term_n.clr_int = 1'b1;
                                end else begin
                                    st_n = ST_PCI_ISSUE;
                                end
                            end
                            TGT_EADDR: begin
                                st_n              = ST_END;
                                term_n.clr_sticky = 1'b1;
                            end
                            default: begin
                                st_n       = ST_END;
                                term_n.err = err_kept(1'b0, mask_err);
                            end
                        endcase
                    end
                end
            end
            ST_MEM_ISSUE: st_n = ST_MEM_WAIT;
            ST_MEM_WAIT: begin
                if (mem_beat) begin
                    st_n   = ST_END;
                    term_n = '0;
                    if (mem_par_err || (dpe_in && beat_q == '0)) begin
                        term_n.err  = err_kept(1'b0, mask_err);
                        term_n.last = 1'b1;
                    end else begin
                        term_n.last = !c_burst || (beat_q == BW'(BURST_BEATS - 1));
                    end
                end
            end
            ST_PCI_ISSUE: st_n = ST_SEL_WAIT;
            ST_SEL_WAIT: begin
                if (pci_devsel) begin
                    st_n = ST_RSP_WAIT;
                end else if (win_hit) begin
                    st_n        = ST_END;
                    term_n      = '0;
                    term_n.last = 1'b1;
                    term_n.ones = c_read;
                    term_n.err  = (c_tgt == TGT_CFG) ? 1'b0 : err_kept(1'b0, mask_err);
                end
            end
            ST_RSP_WAIT: begin
                if (pci_done || pci_tabort || win_hit) begin
                    st_n        = ST_END;
                    term_n      = '0;
                    term_n.last = 1'b1;
                    term_n.err  = (pci_done && !pci_tabort) ? 1'b0
                                                            : err_kept(1'b0, mask_err);
                end
            end
            ST_END: st_n = term_q.last ? ST_IDLE : ST_MEM_WAIT;
            default: st_n = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            term_q  <= '0;
            c_tgt   <= TGT_MEM;
            c_read  <= 1'b0;
            c_burst <= 1'b0;
            beat_q  <= '0;
        end else begin
            state  <= st_n;
            term_q <= term_n;
            if (state == ST_IDLE && cpu_req) begin
                c_tgt   <= tgt_e'(cpu_tgt);
                c_read  <= cpu_read;
                c_burst <= cpu_burst;
            end
            if (state == ST_IDLE) begin
                beat_q <= '0;
            end else if (state == ST_END && !term_q.last) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // ---------------- interrupt request ----------------
    assign dpe_hit  = (state == ST_MEM_WAIT) && mem_beat && dpe_in;
    assign late_dpe = dpe_hit && !mem_par_err && (beat_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend <= 1'b0;
        end else if (late_dpe || pm_par_err || nmi_req) begin
            int_pend <= 1'b1;
        end else if (state == ST_END && term_q.clr_int) begin
            int_pend <= 1'b0;
        end
    end

    // ---------------- helpers ----------------
    assign win_clr = (state == ST_PCI_ISSUE) || (state == ST_SEL_WAIT && pci_devsel);
    assign win_en  = (state == ST_SEL_WAIT) || (state == ST_RSP_WAIT);
    assign win_lim = (state == ST_SEL_WAIT) ? CW'(DEVSEL_CLKS - 1) : CW'(TMO_CLKS - 1);

    berc_window #(.CW(CW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .en    (win_en),
        .limit (win_lim),
        .hit   (win_hit)
    );

    berc_stretch #(.HOLD(DPE_HOLD)) u_dpe (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (dpe_hit),
        .flag  (dpe_flag)
    );

    berc_pm_guard u_pm (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_err (pm_par_err),
        .req     (pm_req),
        .clr     (state == ST_END && term_q.clr_sticky),
        .tabort  (pm_tabort)
    );

    // ---------------- outputs ----------------
    always_comb begin
        mem_go   = 1'b0;
        pci_go   = 1'b0;
        ta       = 1'b0;
        tea      = 1'b0;
        ones_sel = 1'b0;
        unique case (state)
            ST_MEM_ISSUE: mem_go = 1'b1;
            ST_PCI_ISSUE: pci_go = 1'b1;
            ST_END: begin
                ta       = !term_q.err;
                tea      = term_q.err;
                ones_sel = term_q.ones;
            end
            default: ;
        endcase
    end

    assign int_cpu = int_pend;

    // ---------------- assertions ----------------
    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ta && tea)); // R1

    AST_ACK_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (ta || tea) |=> !(ta || tea)); // R1

    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cpu && !ones_sel) |=> int_cpu); // R6

    AST_IACK_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && cpu_tgt == 3'd3 && int_cpu
         && !cpu_pio && !cpu_bad_size) |=> (!pci_go && ones_sel)); // R7

    AST_OOR_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && cpu_tgt == 3'd0 && cpu_oor) |=> !mem_go); // R10

endmodule

// File: tb/tb_berc_top.sv
module tb_berc_top;
    localparam int CLK_PERIOD = 10;
    localparam int DSEL = 7;
    localparam int TMO  = 1980;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_err = 0, cpu_req = 0, cpu_read = 0, cpu_burst = 0, cpu_pio = 0;
    logic cpu_bad_size = 0, cpu_oor = 0;
    logic [2:0] cpu_tgt = 3'd0;
    logic mem_beat = 0, mem_par_err = 0, dpe_in = 0;
    logic pci_devsel = 0, pci_done = 0, pci_tabort = 0;
    logic pm_req = 0, pm_par_err = 0, nmi_req = 0;
    logic mem_go, pci_go, ta, tea, int_cpu, dpe_flag, ones_sel, pm_tabort;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    berc_top #(.DEVSEL_CLKS(DSEL), .TMO_CLKS(TMO), .BURST_BEATS(4), .DPE_HOLD(2)) dut (
        .clk(clk), .rst_n(rst_n), .mask_err(mask_err), .cpu_req(cpu_req),
        .cpu_tgt(cpu_tgt), .cpu_read(cpu_read), .cpu_burst(cpu_burst),
        .cpu_pio(cpu_pio), .cpu_bad_size(cpu_bad_size), .cpu_oor(cpu_oor),
        .mem_go(mem_go), .mem_beat(mem_beat), .mem_par_err(mem_par_err),
        .dpe_in(dpe_in), .pci_go(pci_go), .pci_devsel(pci_devsel),
        .pci_done(pci_done), .pci_tabort(pci_tabort), .pm_req(pm_req),
        .pm_par_err(pm_par_err), .nmi_req(nmi_req), .ta(ta), .tea(tea),
        .int_cpu(int_cpu), .dpe_flag(dpe_flag), .ones_sel(ones_sel),
        .pm_tabort(pm_tabort)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive a processor request for one clock; returns one clock later.
    task automatic issue(input logic [2:0] tgt, input logic rd, input logic bst,
                         input logic pio, input logic bsz, input logic oor);
        cpu_req = 1; cpu_tgt = tgt; cpu_read = rd; cpu_burst = bst;
        cpu_pio = pio; cpu_bad_size = bsz; cpu_oor = oor;
        tick();
        cpu_req = 0; cpu_pio = 0; cpu_bad_size = 0; cpu_oor = 0; cpu_burst = 0;
    endtask

    task automatic beat(input logic par, input logic dpe);
        mem_beat = 1; mem_par_err = par; dpe_in = dpe;
        tick();
        mem_beat = 0; mem_par_err = 0; dpe_in = 0;
    endtask

    task automatic t_reset();
        chk("R1", "reset ta", ta, 0);
        chk("R1", "reset tea", tea, 0);
        chk("R6", "reset int_cpu", int_cpu, 0);
        chk("R5", "reset dpe_flag", dpe_flag, 0);
        chk("R11", "reset pm_tabort", pm_tabort, 0);
    endtask

    task automatic t_mem_single();
        issue(3'd0, 1, 0, 0, 0, 0);
        chk("R1", "mem_go", mem_go, 1);
        tick();
        chk("R1", "no early ta", ta, 0);
        beat(0, 0);
        chk("R1", "ta on beat", ta, 1);
        chk("R1", "no tea on beat", tea, 0);
        tick();
        chk("R1", "ta one clock", ta, 0);
    endtask

    task automatic t_err_causes();
        issue(3'd0, 1, 0, 1, 0, 0);
        chk("R2", "pio tea", tea, 1);
        chk("R2", "pio mem_go", mem_go, 0);
        tick();
        issue(3'd1, 0, 0, 0, 1, 0);
        chk("R2", "bad size tea", tea, 1);
        tick();
        issue(3'd0, 1, 0, 0, 0, 0);
        tick();
        beat(1, 0);
        chk("R2", "mem parity tea", tea, 1);
        chk("R2", "mem parity no ta", ta, 0);
        tick();
    endtask

    task automatic t_mask();
        mask_err = 1;
        issue(3'd0, 0, 0, 0, 1, 0);
        chk("R3", "masked bad size ta", ta, 1);
        chk("R3", "masked bad size tea", tea, 0);
        tick();
        issue(3'd0, 0, 0, 1, 0, 0);
        chk("R3", "pio unmaskable tea", tea, 1);
        tick();
        issue(3'd0, 1, 0, 0, 0, 0);
        tick();
        beat(1, 0);
        chk("R3", "masked parity ta", ta, 1);
        tick();
        mask_err = 0;
    endtask

    task automatic t_burst();
        issue(3'd0, 1, 1, 0, 0, 0);
        tick();
        beat(0, 1);
        chk("R4", "first beat dpe tea", tea, 1);
        chk("R5", "dpe_flag clock 1", dpe_flag, 1);
        tick();
        chk("R5", "dpe_flag clock 2", dpe_flag, 1);
        chk("R4", "burst stopped", ta || tea, 0);
        tick();
        chk("R5", "dpe_flag gone", dpe_flag, 0);
        chk("R4", "no int on first beat", int_cpu, 0);
        issue(3'd0, 1, 1, 0, 0, 0);
        tick();
        for (int b = 0; b < 4; b++) begin
            beat(0, b == 1);
            chk("R12", "burst beat ta", ta, 1);
            if (b == 1) chk("R4", "late dpe int", int_cpu, 1);
            tick();
        end
        tick();
        chk("R12", "no extra beat", ta, 0);
    endtask

    task automatic t_iack();
        chk("R6", "int held", int_cpu, 1);
        issue(3'd3, 1, 0, 0, 0, 0);
        chk("R7", "iack local no pci_go", pci_go, 0);
        chk("R7", "iack ones", ones_sel, 1);
        chk("R7", "iack tea", tea, 1);
        tick();
        chk("R7", "int cleared", int_cpu, 0);
        issue(3'd3, 1, 0, 0, 0, 0);
        chk("R7", "iack forwarded", pci_go, 1);
        tick();
        pci_devsel = 1; tick(); pci_devsel = 0;
        pci_done = 1; tick(); pci_done = 0;
        chk("R7", "forwarded iack ta", ta, 1);
        tick();
        nmi_req = 1; tick(); nmi_req = 0;
        chk("R6", "nmi int", int_cpu, 1);
        repeat (5) tick();
        chk("R6", "nmi int held", int_cpu, 1);
        mask_err = 1;
        issue(3'd3, 1, 0, 0, 0, 0);
        chk("R7", "masked iack ta", ta, 1);
        chk("R7", "masked iack ones", ones_sel, 1);
        tick();
        mask_err = 0;
        chk("R6", "int cleared after iack", int_cpu, 0);
    endtask

    task automatic t_devsel();
        issue(3'd1, 1, 0, 0, 0, 0);
        chk("R8", "pci_go", pci_go, 1);
        repeat (DSEL) tick();
        chk("R8", "still waiting", tea, 0);
        pci_devsel = 1; tick(); pci_devsel = 0;
        chk("R8", "select at limit accepted", ta || tea, 0);
        pci_done = 1; tick(); pci_done = 0;
        chk("R9", "done ta", ta, 1);
        tick();
        issue(3'd1, 1, 0, 0, 0, 0);
        repeat (DSEL) tick();
        chk("R8", "before expiry", tea, 0);
        tick();
        chk("R8", "no select tea", tea, 1);
        chk("R8", "no select ones", ones_sel, 1);
        tick();
        issue(3'd2, 1, 0, 0, 0, 0);
        repeat (DSEL + 1) tick();
        chk("R8", "config no select ta", ta, 1);
        chk("R8", "config read ones", ones_sel, 1);
        tick();
        issue(3'd2, 0, 0, 0, 0, 0);
        repeat (DSEL + 1) tick();
        chk("R8", "config write ta", ta, 1);
        chk("R8", "config write no ones", ones_sel, 0);
        tick();
    endtask

    task automatic t_rsp();
        issue(3'd1, 0, 0, 0, 0, 0);
        tick();
        pci_devsel = 1; tick(); pci_devsel = 0;
        repeat (TMO - 1) tick();
        chk("R9", "before timeout", tea, 0);
        tick();
        chk("R9", "timeout tea", tea, 1);
        tick();
        issue(3'd1, 0, 0, 0, 0, 0);
        tick();
        pci_devsel = 1; tick(); pci_devsel = 0;
        pci_tabort = 1; tick(); pci_tabort = 0;
        chk("R9", "target abort tea", tea, 1);
        tick();
    endtask

    task automatic t_oor();
        issue(3'd0, 1, 0, 0, 0, 1);
        chk("R10", "oor read ta", ta, 1);
        chk("R10", "oor read ones", ones_sel, 1);
        chk("R10", "oor read mem_go", mem_go, 0);
        tick();
        issue(3'd0, 0, 0, 0, 0, 1);
        chk("R10", "oor write ta", ta, 1);
        chk("R10", "oor write no ones", ones_sel, 0);
        chk("R10", "oor write mem_go", mem_go, 0);
        tick();
        chk("R10", "oor write no later mem_go", mem_go, 0);
    endtask

    task automatic t_sticky();
        pm_req = 1; tick(); pm_req = 0;
        chk("R11", "no abort before error", pm_tabort, 0);
        pm_par_err = 1; tick(); pm_par_err = 0;
        chk("R6", "pm parity int", int_cpu, 1);
        pm_req = 1; tick(); pm_req = 0;
        chk("R11", "abort after error", pm_tabort, 1);
        issue(3'd4, 1, 0, 0, 0, 0);
        chk("R11", "error address read ta", ta, 1);
        tick();
        pm_req = 1; tick(); pm_req = 0;
        chk("R11", "abort cleared", pm_tabort, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_mem_single();
        t_err_causes();
        t_mask();
        t_burst();
        t_iack();
        t_devsel();
        t_rsp();
        t_oor();
        t_sticky();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule